// File: doc/BRIEF.md
# Bulk IN Endpoint Transmitter

This block answers a host IN token on the device side of a USB function. It serves a small set of endpoints. When a decoded token is addressed to this device, names an endpoint that exists and that endpoint is configured for the IN direction, the block checks the endpoint's externally held status, its data-set flag and its FIFO byte count. It then sends one of three things to a byte serializer: a STALL handshake, a NAK handshake, or a data packet. A data packet carries a DATA0 or DATA1 PID taken from a per-endpoint toggle, then the FIFO bytes in order, then a CRC16.

After a data packet the block waits for the host's verdict. An ACK strobe clears the endpoint FIFO and its data-set flag, flips the toggle and writes READY to the status. A timeout strobe writes TX_ERR and rewinds the FIFO read pointer, so the next IN token resends the same bytes under the same PID. A byte count larger than the endpoint's maximum payload sends nothing, raises an error pulse and writes STALL.

States: IDLE (waits for a token), CHECK (inspects status, flag and count), SEND_HS (one handshake byte), SEND_PID, SEND_DATA, CRC_LO, CRC_HI and WAIT_ACK. Transitions: IDLE→CHECK on an accepted token. CHECK→IDLE when the status is INVALID or the payload is overlong. CHECK→SEND_HS when the status is STALL or no data is set. CHECK→SEND_PID otherwise. SEND_HS→IDLE on the byte being accepted. SEND_PID→SEND_DATA, or →CRC_LO when the count is zero. SEND_DATA→CRC_LO after the last payload byte. CRC_LO→CRC_HI→WAIT_ACK. WAIT_ACK→IDLE on ACK or timeout.

Top module: `bulk_in_tx`

## Requirements
- R1: A token gets a response only when tok_pid is 4'b1001 (IN), tok_addr equals dev_addr, tok_ep is below the endpoint count and that endpoint's cfg_in_dir bit is 1. Any other token gets no byte and no status write.
- R2: An endpoint whose status is INVALID (2'd3) receives no byte and no status write.
- R3: An endpoint whose status is STALL (2'd2) receives the single byte 8'h1E with tx_last set.
- R4: An endpoint whose data_set bit is 0 (and whose status is READY 2'd0 or TX_ERR 2'd1) receives the single byte 8'h5A with tx_last set.
- R5: A data packet starts with 8'hC3 (DATA0) when the endpoint toggle is 0 and 8'h4B (DATA1) when it is 1. Every toggle is 0 after reset.
- R6: After the PID, the packet carries fifo_count bytes in FIFO order, then the CRC16 (reflected polynomial 16'hA001, seed 16'hFFFF, remainder inverted) low byte then high byte, with tx_last only on the high byte. A count of zero sends only PID and CRC. fifo_rd pulses exactly on each accepted payload byte.
- R7: If fifo_count exceeds the endpoint's cfg_maxpkt, no byte is sent, tx_err pulses and STALL is written to the endpoint status.
- R8: hs_ack in WAIT_ACK pulses fifo_clear and dataset_clr, writes READY and flips the endpoint toggle.
- R9: hs_timeout in WAIT_ACK (without hs_ack) pulses fifo_rewind and writes TX_ERR. The next IN token resends the same bytes with the same PID.
- R10: While tx_valid is high and tx_ready low, tx_valid stays high and tx_data holds.
- R11: After reset, tx_valid, st_we, fifo_rd and tx_err are low.
- R12: A token arriving while a response is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_addr | input | 7 | Device address |
| tok_valid | input | 1 | Decoded token strobe |
| tok_pid | input | 4 | Token PID |
| tok_addr | input | 7 | Token address |
| tok_ep | input | 4 | Token endpoint number |
| cfg_in_dir | input | NUM_EP | Per-endpoint IN-direction enable |
| cfg_maxpkt | input | NUM_EP*CNT_W | Per-endpoint maximum payload |
| ep_status | input | NUM_EP*2 | Per-endpoint status (0 READY, 1 TX_ERR, 2 STALL, 3 INVALID) |
| fifo_count | input | NUM_EP*CNT_W | Per-endpoint FIFO byte count |
| data_set | input | NUM_EP | Per-endpoint packet-ready flag |
| fifo_rdata | input | 8 | Head byte of the selected FIFO |
| hs_ack | input | 1 | Host ACK received strobe |
| hs_timeout | input | 1 | ACK wait timeout strobe |
| tx_valid | output | 1 | Byte valid to serializer |
| tx_ready | input | 1 | Serializer accepts byte |
| tx_data | output | 8 | Byte to serializer |
| tx_last | output | 1 | Final byte of the packet |
| fifo_ep | output | EPI_W | Endpoint whose FIFO is addressed |
| fifo_rd | output | 1 | Pop one FIFO byte |
| fifo_rewind | output | 1 | Return FIFO read pointer to packet start |
| fifo_clear | output | 1 | Empty the FIFO |
| dataset_clr | output | 1 | Clear the data-set flag |
| st_we | output | 1 | Status write strobe |
| st_ep | output | EPI_W | Endpoint of the status write |
| st_val | output | 2 | Status value written |
| tx_err | output | 1 | Overlong payload error pulse |

## Verification
The token is captured at one clock edge. The following cycle is CHECK, which is silent on the serializer but carries the overlong STALL write and the error pulse. The first response byte is valid in the cycle after that. The bench samples tx_valid at exactly those two negative edges after each token. ACK and timeout results (status write, clear, rewind) appear combinationally in the same cycle as the strobe. The bench's FIFO model applies them at the next edge, and the bench reads that model one half-cycle later. Every accepted byte and every status write is compared against queues filled from the requirements as each stimulus is issued, so any early, late or extra byte is a miscompare.

// File: rtl/bulk_in_pkg.sv
package bulk_in_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SEND_HS,
        ST_SEND_PID,
        ST_SEND_DATA,
        ST_CRC_LO,
        ST_CRC_HI,
        ST_WAIT_ACK
    } tx_state_e;

    typedef enum logic [1:0] {
        EPS_READY   = 2'd0,
        EPS_TX_ERR  = 2'd1,
        EPS_STALL   = 2'd2,
        EPS_INVALID = 2'd3
    } ep_stat_e;

    localparam logic [3:0] PID_IN    = 4'b1001;
    localparam logic [7:0] BYTE_DATA0 = 8'hC3;
    localparam logic [7:0] BYTE_DATA1 = 8'h4B;
    localparam logic [7:0] BYTE_NAK   = 8'h5A;
    localparam logic [7:0] BYTE_STALL = 8'h1E;
endpackage

// File: rtl/bulk_in_crc16.sv
module bulk_in_crc16 #(
    parameter logic [15:0] POLY_REV = 16'hA001,
    parameter logic [15:0] SEED     = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc_o
);
    logic [15:0] crc_q;
    logic [15:0] crc_d;

    always_comb begin
        logic [15:0] c;
        logic        fb;
        c = crc_q;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ din[i];
            c  = {1'b0, c[15:1]};
            if (fb) begin
                c = c ^ POLY_REV;
            end
        end
        crc_d = c;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_q <= SEED;
        end else if (en) begin
            crc_q <= crc_d;
        end
    end

    assign crc_o = ~crc_q;
endmodule

// File: rtl/bulk_in_token_check.sv
module bulk_in_token_check
    import bulk_in_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int EPN_W  = 4,
    parameter int ADDR_W = 7,
    localparam int EPI_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic [3:0]        tok_pid,
    input  logic [ADDR_W-1:0] tok_addr,
    input  logic [EPN_W-1:0]  tok_ep,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [NUM_EP-1:0] cfg_in_dir,
    output logic              hit,
    output logic [EPI_W-1:0]  ep_idx
);
    localparam logic [EPN_W:0] EP_LIM = (EPN_W + 1)'(NUM_EP);

    logic in_range;

    assign in_range = {1'b0, tok_ep} < EP_LIM;
    assign ep_idx   = tok_ep[EPI_W-1:0];
    assign hit      = (tok_pid == PID_IN) && (tok_addr == dev_addr) &&
                      in_range && cfg_in_dir[ep_idx];
endmodule

// File: rtl/bulk_in_toggle_bank.sv
module bulk_in_toggle_bank #(
    parameter int NUM_EP = 4,
    localparam int EPI_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flip,
    input  logic [EPI_W-1:0] ep,
    output logic             tog
);
    logic [NUM_EP-1:0] tog_q;

    for (genvar g = 0; g < NUM_EP; g++) begin : g_tog
        always_ff @(posedge clk) begin
            if (rst) begin
                tog_q[g] <= 1'b0;
            end else if (flip && (ep == EPI_W'(g))) begin
                tog_q[g] <= ~tog_q[g];
            end
        end
    end

    assign tog = tog_q[ep];
endmodule

// File: rtl/bulk_in_tx.sv
module bulk_in_tx
    import bulk_in_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int CNT_W  = 7,
    parameter int ADDR_W = 7,
    parameter int EPN_W  = 4,
    localparam int EPI_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       dev_addr,
    input  logic                    tok_valid,
    input  logic [3:0]              tok_pid,
    input  logic [ADDR_W-1:0]       tok_addr,
    input  logic [EPN_W-1:0]        tok_ep,
    input  logic [NUM_EP-1:0]       cfg_in_dir,
    input  logic [NUM_EP*CNT_W-1:0] cfg_maxpkt,
    input  logic [NUM_EP*2-1:0]     ep_status,
    input  logic [NUM_EP*CNT_W-1:0] fifo_count,
    input  logic [NUM_EP-1:0]       data_set,
    input  logic [7:0]              fifo_rdata,
    input  logic                    hs_ack,
    input  logic                    hs_timeout,
    output logic                    tx_valid,
    input  logic                    tx_ready,
    output logic [7:0]              tx_data,
    output logic                    tx_last,
    output logic [EPI_W-1:0]        fifo_ep,
    output logic                    fifo_rd,
    output logic                    fifo_rewind,
    output logic                    fifo_clear,
    output logic                    dataset_clr,
    output logic                    st_we,
    output logic [EPI_W-1:0]        st_ep,
    output logic [1:0]              st_val,
    output logic                    tx_err
);
    tx_state_e        state_q, state_d;
    logic [EPI_W-1:0] ep_q;
    logic [CNT_W-1:0] rem_q;
    logic [7:0]       hs_byte_q;

    logic             tok_hit;
    logic [EPI_W-1:0] tok_idx;
    logic             tog;
    logic             tog_flip;
    logic             crc_clr;
    logic             crc_en;
    logic [15:0]      crc_val;

    ep_stat_e         cur_stat;
    logic [CNT_W-1:0] cur_cnt;
    logic [CNT_W-1:0] cur_max;
    logic             cur_ds;
    logic             overlong;

    bulk_in_token_check #(
        .NUM_EP (NUM_EP),
        .EPN_W  (EPN_W),
        .ADDR_W (ADDR_W)
    ) u_tok (
        .tok_pid    (tok_pid),
        .tok_addr   (tok_addr),
        .tok_ep     (tok_ep),
        .dev_addr   (dev_addr),
        .cfg_in_dir (cfg_in_dir),
        .hit        (tok_hit),
        .ep_idx     (tok_idx)
    );

    bulk_in_toggle_bank #(
        .NUM_EP (NUM_EP)
    ) u_tog (
        .clk  (clk),
        .rst  (rst),
        .flip (tog_flip),
        .ep   (ep_q),
        .tog  (tog)
    );

    bulk_in_crc16 u_crc (
        .clk   (clk),
        .rst   (rst),
        .clear (crc_clr),
        .en    (crc_en),
        .din   (fifo_rdata),
        .crc_o (crc_val)
    );

    assign cur_stat = ep_stat_e'(ep_status[ep_q*2 +: 2]);
    assign cur_cnt  = fifo_count[ep_q*CNT_W +: CNT_W];
    assign cur_max  = cfg_maxpkt[ep_q*CNT_W +: CNT_W];
    assign cur_ds   = data_set[ep_q];
    assign overlong = cur_cnt > cur_max;

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ep_q      <= '0;
            rem_q     <= '0;
            hs_byte_q <= BYTE_NAK;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (tok_valid && tok_hit) begin
                        ep_q <= tok_idx;
                    end
                end
                ST_CHECK: begin
                    rem_q     <= cur_cnt;
                    hs_byte_q <= (cur_stat == EPS_STALL) ? BYTE_STALL : BYTE_NAK;
                end
                ST_SEND_DATA: begin
                    if (tx_ready) begin
                        rem_q <= rem_q - CNT_W'(1);
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tok_valid && tok_hit) begin
                    state_d = ST_CHECK;
                end
            end
            ST_CHECK: begin
                unique case (cur_stat)
                    EPS_INVALID: state_d = ST_IDLE;
                    EPS_STALL:   state_d = ST_SEND_HS;
                    default: begin
                        if (!cur_ds) begin
                            state_d = ST_SEND_HS;
                        end else if (overlong) begin
                            state_d = ST_IDLE;
                        end else begin
                            state_d = ST_SEND_PID;
                        end
                    end
                endcase
            end
            ST_SEND_HS: begin
                if (tx_ready) begin
                    state_d = ST_IDLE;
                end
            end
            ST_SEND_PID: begin
                if (tx_ready) begin
                    state_d = (rem_q == '0) ? ST_CRC_LO : ST_SEND_DATA;
                end
            end
            ST_SEND_DATA: begin
                if (tx_ready && (rem_q == CNT_W'(1))) begin
                    state_d = ST_CRC_LO;
                end
            end
            ST_CRC_LO: begin
                if (tx_ready) begin
                    state_d = ST_CRC_HI;
                end
            end
            ST_CRC_HI: begin
                if (tx_ready) begin
                    state_d = ST_WAIT_ACK;
                end
            end
            ST_WAIT_ACK: begin
                if (hs_ack || hs_timeout) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_valid    = 1'b0;
        tx_data     = 8'h00;
        tx_last     = 1'b0;
        fifo_ep     = ep_q;
        fifo_rd     = 1'b0;
        fifo_rewind = 1'b0;
        fifo_clear  = 1'b0;
        dataset_clr = 1'b0;
        st_we       = 1'b0;
        st_ep       = ep_q;
        st_val      = EPS_READY;
        tx_err      = 1'b0;
        tog_flip    = 1'b0;
        crc_clr     = 1'b0;
        crc_en      = 1'b0;
        unique case (state_q)
            ST_CHECK: begin
                crc_clr = 1'b1;
                if ((cur_stat == EPS_READY || cur_stat == EPS_TX_ERR) &&
                    cur_ds && overlong) begin
                    st_we  = 1'b1;
                    st_val = EPS_STALL;
                    tx_err = 1'b1;
                end
            end
            ST_SEND_HS: begin
                tx_valid = 1'b1;
                tx_data  = hs_byte_q;
                tx_last  = 1'b1;
            end
            ST_SEND_PID: begin
                tx_valid = 1'b1;
                tx_data  = tog ? BYTE_DATA1 : BYTE_DATA0;
            end
            ST_SEND_DATA: begin
                tx_valid = 1'b1;
                tx_data  = fifo_rdata;
                fifo_rd  = tx_ready;
                crc_en   = tx_ready;
            end
            ST_CRC_LO: begin
                tx_valid = 1'b1;
                tx_data  = crc_val[7:0];
            end
            ST_CRC_HI: begin
                tx_valid = 1'b1;
                tx_data  = crc_val[15:8];
                tx_last  = 1'b1;
            end
            ST_WAIT_ACK: begin
                if (hs_ack) begin
                    fifo_clear  = 1'b1;
                    dataset_clr = 1'b1;
                    tog_flip    = 1'b1;
                    st_we       = 1'b1;
                    st_val      = EPS_READY;
                end else if (hs_timeout) begin
                    fifo_rewind = 1'b1;
                    st_we       = 1'b1;
                    st_val      = EPS_TX_ERR;
                end
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/bulk_in_tx_chk.sv
module bulk_in_tx_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       tx_last,
    input logic       fifo_rd,
    input logic       fifo_rewind,
    input logic       fifo_clear,
    input logic       hs_ack,
    input logic       hs_timeout,
    input logic       tx_err
);
    // R10
    hold_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R6
    last_valid_chk: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);

    // R6
    pop_accept_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> (tx_valid && tx_ready));

    // R8
    clear_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_clear |-> hs_ack);

    // R9
    rewind_on_to_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rewind |-> (hs_timeout && !hs_ack));

    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        tx_err |=> !tx_valid);
endmodule

bind bulk_in_tx bulk_in_tx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .tx_last     (tx_last),
    .fifo_rd     (fifo_rd),
    .fifo_rewind (fifo_rewind),
    .fifo_clear  (fifo_clear),
    .hs_ack      (hs_ack),
    .hs_timeout  (hs_timeout),
    .tx_err      (tx_err)
);

// File: tb/bulk_in_tx_bench.sv
`timescale 1ns/1ps
module bulk_in_tx_bench;
    localparam int NEP = 4;
    localparam int CW  = 7;
    localparam logic [6:0] MYADDR = 7'h2A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic            tok_valid = 1'b0;
    logic [3:0]      tok_pid = 4'h0;
    logic [6:0]      tok_addr = 7'h0;
    logic [3:0]      tok_ep = 4'h0;
    logic [NEP-1:0]  cfg_in_dir = 4'b1111;
    logic [NEP*CW-1:0] cfg_maxpkt;
    logic [NEP*2-1:0]  ep_status;
    logic [NEP*CW-1:0] fifo_count;
    logic [NEP-1:0]  data_set;
    logic [7:0]      fifo_rdata;
    logic            hs_ack = 1'b0;
    logic            hs_timeout = 1'b0;
    logic            tx_valid, tx_last, tx_ready;
    logic [7:0]      tx_data;
    logic [1:0]      fifo_ep, st_ep;
    logic            fifo_rd, fifo_rewind, fifo_clear, dataset_clr;
    logic            st_we, tx_err;
    logic [1:0]      st_val;

    // environment state: FIFOs, flags, external status registers
    logic [7:0] mem [NEP][64];
    int         flen [NEP] = '{default: 0};
    int         fptr [NEP] = '{default: 0};
    logic       fds  [NEP] = '{default: 1'b0};
    logic [1:0] stat [NEP] = '{default: 2'd0};
    int         maxp [NEP] = '{8, 8, 8, 4};

    logic       cmd_ld = 1'b0;
    int         cmd_ep = 0;
    int         cmd_len = 0;
    logic       cmd_ds = 1'b0;
    logic       cmd_st = 1'b0;
    logic [1:0] cmd_st_val = 2'd0;

    for (genvar g = 0; g < NEP; g++) begin : g_env
        assign fifo_count[g*CW +: CW] = CW'(flen[g]);
        assign cfg_maxpkt[g*CW +: CW] = CW'(maxp[g]);
        assign ep_status[g*2 +: 2]    = stat[g];
        assign data_set[g]            = fds[g];
    end
    assign fifo_rdata = mem[fifo_ep][fptr[fifo_ep] & 63];

    always @(posedge clk) begin
        if (cmd_ld) begin
            flen[cmd_ep] <= cmd_len;
            fds[cmd_ep]  <= cmd_ds;
            fptr[cmd_ep] <= 0;
        end
        if (cmd_st) stat[cmd_ep] <= cmd_st_val;
        if (st_we) stat[st_ep] <= st_val;
        if (fifo_rd) fptr[fifo_ep] <= fptr[fifo_ep] + 1;
        if (fifo_rewind) fptr[fifo_ep] <= 0;
        if (fifo_clear) begin
            fptr[fifo_ep] <= 0;
            flen[fifo_ep] <= 0;
        end
        if (dataset_clr) fds[fifo_ep] <= 1'b0;
    end

    bulk_in_tx u_bulk_in_tx (
        .clk(clk), .rst(rst), .dev_addr(MYADDR),
        .tok_valid(tok_valid), .tok_pid(tok_pid), .tok_addr(tok_addr), .tok_ep(tok_ep),
        .cfg_in_dir(cfg_in_dir), .cfg_maxpkt(cfg_maxpkt), .ep_status(ep_status),
        .fifo_count(fifo_count), .data_set(data_set), .fifo_rdata(fifo_rdata),
        .hs_ack(hs_ack), .hs_timeout(hs_timeout),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .fifo_ep(fifo_ep), .fifo_rd(fifo_rd), .fifo_rewind(fifo_rewind),
        .fifo_clear(fifo_clear), .dataset_clr(dataset_clr),
        .st_we(st_we), .st_ep(st_ep), .st_val(st_val), .tx_err(tx_err)
    );

    // serializer back-pressure
    logic stall_en = 1'b0;
    int   rcnt = 0;
    logic rdy_r = 1'b1;
    assign tx_ready = rdy_r;
    always @(posedge clk) begin
        #2;
        rcnt = rcnt + 1;
        rdy_r = stall_en ? ((rcnt % 3) != 0) : 1'b1;
    end

    int nvec = 0;
    int nfail = 0;
    int err_seen = 0;
    bit done = 1'b0;
    logic [8:0] exp_q [$];
    logic [3:0] st_q  [$];
    bit         exp_tog [NEP] = '{default: 1'b0};

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    // reference comparison on every clock
    bit         held = 1'b0;
    logic [7:0] held_data = 8'h00;
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (held) begin
                chk(tx_valid && tx_data == held_data, "R10 hold", {tx_valid, tx_data}, {1'b1, held_data});
            end
            held = tx_valid && !tx_ready;
            held_data = tx_data;
            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1/R12 unexpected byte", tx_data, 0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    chk({tx_last, tx_data} == e, "R5/R6 byte", {tx_last, tx_data}, e);
                end
            end
            if (st_we) begin
                if (st_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected status write", {st_ep, st_val}, 0);
                end else begin
                    logic [3:0] s;
                    s = st_q.pop_front();
                    chk({st_ep, st_val} == s, "R7/R8/R9 status write", {st_ep, st_val}, s);
                end
            end
            if (tx_err) err_seen++;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic load(input int ep, input int n, input bit ds, input int seed);
        for (int i = 0; i < n; i++) mem[ep][i] = 8'(seed + i * 37);
        cmd_ld = 1'b1; cmd_ep = ep; cmd_len = n; cmd_ds = ds;
        tick();
        cmd_ld = 1'b0;
    endtask

    task automatic set_stat(input int ep, input logic [1:0] v);
        cmd_st = 1'b1; cmd_ep = ep; cmd_st_val = v;
        tick();
        cmd_st = 1'b0;
    endtask

    function automatic logic [15:0] crc_of(input int ep, input int n);
        logic [15:0] r;
        r = 16'hFFFF;
        for (int k = 0; k < n; k++) begin
            for (int b = 0; b < 8; b++) begin
                if ((r[0] ^ mem[ep][k][b]) == 1'b1) r = (r >> 1) ^ 16'hA001;
                else r = r >> 1;
            end
        end
        return ~r;
    endfunction

    task automatic expect_pkt(input int ep, input int n);
        logic [15:0] c;
        c = crc_of(ep, n);
        exp_q.push_back({1'b0, exp_tog[ep] ? 8'h4B : 8'hC3});
        for (int i = 0; i < n; i++) exp_q.push_back({1'b0, mem[ep][i]});
        exp_q.push_back({1'b0, c[7:0]});
        exp_q.push_back({1'b1, c[15:8]});
    endtask

    task automatic token(input logic [3:0] pid, input logic [6:0] addr, input logic [3:0] ep,
                         input bit resp, input string tag);
        tick();
        tok_valid = 1'b1; tok_pid = pid; tok_addr = addr; tok_ep = ep;
        tick();
        tok_valid = 1'b0;
        @(negedge clk);
        chk(tx_valid == 1'b0, {tag, " check cycle"}, tx_valid, 0);
        @(negedge clk);
        chk(tx_valid == resp, {tag, " first byte"}, tx_valid, resp);
    endtask

    task automatic wait_done();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic quiet(input string tag);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!tx_valid && !st_we, tag, {tx_valid, st_we}, 0);
        end
    endtask

    task automatic ack(input int ep);
        wait_done();
        st_q.push_back({2'(ep), 2'd0});
        tick();
        hs_ack = 1'b1;
        tick();
        hs_ack = 1'b0;
        exp_tog[ep] = ~exp_tog[ep];
        @(negedge clk);
        chk(fds[ep] == 1'b0 && flen[ep] == 0 && st_q.size() == 0, "R8 ack effects",
            {fds[ep], 8'(flen[ep])}, 0);
    endtask

    task automatic timeout(input int ep);
        wait_done();
        st_q.push_back({2'(ep), 2'd1});
        tick();
        hs_timeout = 1'b1;
        tick();
        hs_timeout = 1'b0;
        @(negedge clk);
        chk(fptr[ep] == 0 && fds[ep] == 1'b1 && st_q.size() == 0, "R9 timeout effects",
            fptr[ep], 0);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nvec++;
        nfail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!tx_valid && !st_we && !fifo_rd && !tx_err, "R11 reset outputs",
            {tx_valid, st_we, fifo_rd, tx_err}, 0);

        // R4 NAK when no data is set
        exp_q.push_back({1'b1, 8'h5A});
        token(4'b1001, MYADDR, 4'd1, 1'b1, "R4");
        wait_done();
        quiet("R4 after NAK");

        // R5 R6 R8 R10 data packet with back-pressure, then ACK
        stall_en = 1'b1;
        load(1, 5, 1'b1, 8'h11);
        expect_pkt(1, 5);
        token(4'b1001, MYADDR, 4'd1, 1'b1, "R5");
        ack(1);

        // R5 DATA1 after toggle flip, R9 timeout then identical resend
        load(1, 3, 1'b1, 8'h80);
        expect_pkt(1, 3);
        token(4'b1001, MYADDR, 4'd1, 1'b1, "R5 data1");
        timeout(1);
        expect_pkt(1, 3);
        token(4'b1001, MYADDR, 4'd1, 1'b1, "R9 resend");
        ack(1);

        // R6 zero-length packet
        stall_en = 1'b0;
        load(2, 0, 1'b1, 0);
        expect_pkt(2, 0);
        token(4'b1001, MYADDR, 4'd2, 1'b1, "R6 zlp");
        ack(2);

        // R7 overlong payload, then R3 STALL handshake
        begin
            int e0;
            e0 = err_seen;
            load(3, 6, 1'b1, 8'h05);
            st_q.push_back({2'd3, 2'd2});
            token(4'b1001, MYADDR, 4'd3, 1'b0, "R7");
            quiet("R7 no bytes");
            chk(err_seen == e0 + 1 && st_q.size() == 0, "R7 error pulse", err_seen - e0, 1);
        end
        exp_q.push_back({1'b1, 8'h1E});
        token(4'b1001, MYADDR, 4'd3, 1'b1, "R3");
        wait_done();
        quiet("R3 after STALL");

        // R2 INVALID endpoint is silent
        load(0, 2, 1'b1, 8'h40);
        set_stat(0, 2'd3);
        token(4'b1001, MYADDR, 4'd0, 1'b0, "R2");
        quiet("R2 silent");

        // R1 token filtering
        load(1, 2, 1'b1, 8'h22);
        token(4'b1001, 7'h2B, 4'd1, 1'b0, "R1 addr");
        quiet("R1 addr silent");
        token(4'b0001, MYADDR, 4'd1, 1'b0, "R1 pid");
        quiet("R1 pid silent");
        token(4'b1001, MYADDR, 4'd5, 1'b0, "R1 ep range");
        quiet("R1 range silent");
        cfg_in_dir = 4'b1011;
        token(4'b1001, MYADDR, 4'd2, 1'b0, "R1 direction");
        quiet("R1 dir silent");
        cfg_in_dir = 4'b1111;

        // R12 token while busy is ignored
        stall_en = 1'b1;
        load(1, 6, 1'b1, 8'h33);
        expect_pkt(1, 6);
        token(4'b1001, MYADDR, 4'd1, 1'b1, "R12");
        tick();
        tick();
        tok_valid = 1'b1; tok_pid = 4'b1001; tok_addr = MYADDR; tok_ep = 4'd1;
        tick();
        tok_valid = 1'b0;
        ack(1);
        stall_en = 1'b0;
        quiet("R12 no second response");

        finish_up();
    end
endmodule